// File: doc/BRIEF.md
# Multiplexed Bus Demultiplexer and Strobe Decoder

This block sits between a CPU with a time-shared address/data bus and the memories and I/O devices of a small system. During the first part of every bus cycle the CPU places the low address byte on the shared lines and raises an address-strobe pulse. The block captures that byte while the pulse is high and holds it after the pulse ends. It joins the held byte to the upper byte, which comes from dedicated lines, to form a stable 16-bit address that lasts for the whole cycle.

The CPU has a single active-low read and a single active-low write, plus a level that tells memory cycles from I/O cycles. The block splits these into four active-low strobes: memory read, memory write, I/O read and I/O write. It decodes the upper address bits into a chip select for a ROM window (0000h-1FFFh) and one for a RAM window (2000h-3FFFh). It passes the low 13 address bits as the offset inside a chip. It also drives the data buffer enable and direction.

All outputs are registered on the system clock, so every output reflects the inputs sampled at the previous rising edge. The reset is synchronous and active high.

Top module: `bdx_bus_glue`

## Requirements
- R1: While `ale` is high at a rising edge, `addr[7:0]` takes the value of `ad_in` after that edge. While `ale` is low at an edge, `addr[7:0]` keeps its previous value.
- R2: `addr[15:8]` takes the value of `a_hi` sampled at every rising edge, whatever the state of `ale`.
- R3: With `io_m`=0 (memory), `rd_n`=0 drives `memr_n` low and `wr_n`=0 drives `memw_n` low. With `io_m`=1 (I/O), they drive `ior_n` and `iow_n` low instead. Each strobe follows one cycle after its inputs are sampled.
- R4: At most one of the four strobes is low at any time. When `rd_n` and `wr_n` are both low, `bus_err` goes high and all four strobes stay high.
- R5: `rom_cs_n` is low only in a memory cycle (a memory read or memory write strobe is being produced) whose address lies in 0000h-1FFFh.
- R6: `ram_cs_n` is low only in a memory cycle whose address lies in 2000h-3FFFh. Neither chip select is low during I/O cycles, idle cycles or error cycles, or for addresses at 4000h and above.
- R7: `ram_we_n` is low only for a memory write whose address lies in the RAM window. A memory write into the ROM window produces no chip write, although `memw_n` still goes low.
- R8: `data_oe_n` is low exactly when one of the four strobes is low. `data_dir` is 1 (toward the CPU) for memory or I/O reads, and 0 otherwise.
- R9: `chip_off` equals `addr[12:0]`, the offset within a 13-bit chip window.
- R10: A rising edge with `rst` high sets `addr` to 0 and `bus_err` to 0, and sets every strobe, chip select, `ram_we_n` and `data_oe_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ale | input | 1 | Address strobe pulse from the CPU |
| ad_in | input | 8 | Shared low address / data lines |
| a_hi | input | 8 | Dedicated upper address lines |
| io_m | input | 1 | 0 = memory cycle, 1 = I/O cycle |
| rd_n | input | 1 | CPU read, active low |
| wr_n | input | 1 | CPU write, active low |
| addr | output | 16 | Demultiplexed address |
| chip_off | output | 13 | Offset inside the selected chip |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| rom_cs_n | output | 1 | ROM chip select, active low |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| data_oe_n | output | 1 | Data buffer enable, active low |
| data_dir | output | 1 | Data buffer direction, 1 = toward CPU |
| bus_err | output | 1 | Read and write asserted together |

## Verification
The bench puts junk on the shared lines once the address strobe has fallen. A latch that stays transparent would then show that junk on the low address instead of the captured byte. It probes the window edges 1FFFh, 2000h, 3FFFh and 4000h. An off-by-one tag compare, or a decode that ignores a bit, would select the wrong chip or a chip outside both windows. It writes into the ROM window, where a decoder that derives the write enable from the memory write strobe alone would corrupt a write. It also drives read and write low together and runs I/O cycles at addresses inside the memory windows. A design that leaked a strobe or a chip select in those cases would show a second active strobe or a stray select.

// File: rtl/bdx_pkg.sv
package bdx_pkg;

  // Active-high internal view of the four split strobes.
  typedef struct packed {
    logic memr;
    logic memw;
    logic ior;
    logic iow;
  } strobe_t;

  function automatic logic any_strobe(strobe_t s);
    return s.memr | s.memw | s.ior | s.iow;
  endfunction

  function automatic logic is_read(strobe_t s);
    return s.memr | s.ior;
  endfunction

endpackage

// File: rtl/bdx_addr_latch.sv
module bdx_addr_latch #(
  parameter int LO_W = 8,
  parameter int HI_W = 8,
  localparam int AW  = LO_W + HI_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ale,
  input  logic [LO_W-1:0] ad_in,
  input  logic [HI_W-1:0] hi_in,
  output logic [AW-1:0]   addr_nx,
  output logic [AW-1:0]   addr_q
);

  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic [LO_W-1:0] lo_nx;

  // The held byte follows the shared lines while the strobe is high.
  always_comb begin
    lo_nx   = ale ? ad_in : lo_q;
    addr_nx = {hi_in, lo_nx};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_nx;
      hi_q <= hi_in;
    end
  end

  assign addr_q = {hi_q, lo_q};

endmodule

// File: rtl/bdx_strobe_split.sv
module bdx_strobe_split
  import bdx_pkg::*;
(
  input  logic    io_m,
  input  logic    rd_n,
  input  logic    wr_n,
  output strobe_t stb,
  output logic    clash
);

  logic rd, wr, ok;

  always_comb begin
    rd    = ~rd_n;
    wr    = ~wr_n;
    clash = rd & wr;
    ok    = ~clash;
    stb.memr = ok & rd & ~io_m;
    stb.memw = ok & wr & ~io_m;
    stb.ior  = ok & rd &  io_m;
    stb.iow  = ok & wr &  io_m;
  end

endmodule

// File: rtl/bdx_region_decode.sv
module bdx_region_decode #(
  parameter int              TAG_W = 3,
  parameter logic [TAG_W-1:0] TAG  = '0
) (
  input  logic [TAG_W-1:0] tag_in,
  output logic             hit
);

  assign hit = (tag_in == TAG);

endmodule

// File: rtl/bdx_bus_glue.sv
module bdx_bus_glue
  import bdx_pkg::*;
#(
  parameter int          LO_W     = 8,
  parameter int          HI_W     = 8,
  parameter int          OFF_W    = 13,
  parameter logic [15:0] ROM_BASE = 16'h0000,
  parameter logic [15:0] RAM_BASE = 16'h2000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ale,
  input  logic [LO_W-1:0]      ad_in,
  input  logic [HI_W-1:0]      a_hi,
  input  logic                 io_m,
  input  logic                 rd_n,
  input  logic                 wr_n,
  output logic [LO_W+HI_W-1:0] addr,
  output logic [OFF_W-1:0]     chip_off,
  output logic                 memr_n,
  output logic                 memw_n,
  output logic                 ior_n,
  output logic                 iow_n,
  output logic                 rom_cs_n,
  output logic                 ram_cs_n,
  output logic                 ram_we_n,
  output logic                 data_oe_n,
  output logic                 data_dir,
  output logic                 bus_err
);

  localparam int AW      = LO_W + HI_W;
  localparam int TAG_W   = AW - OFF_W;
  localparam int NREG    = 2;
  localparam int ROM_IDX = 0;
  localparam int RAM_IDX = 1;
  localparam logic [AW-1:0] REGION_BASE [NREG] = '{ROM_BASE[AW-1:0], RAM_BASE[AW-1:0]};

  logic [AW-1:0]   addr_nx;
  logic [AW-1:0]   addr_q;
  strobe_t         stb;
  logic            clash;
  logic [NREG-1:0] hit;
  logic            mem_cyc;

  bdx_addr_latch #(.LO_W(LO_W), .HI_W(HI_W)) latch_i (
    .clk     (clk),
    .rst     (rst),
    .ale     (ale),
    .ad_in   (ad_in),
    .hi_in   (a_hi),
    .addr_nx (addr_nx),
    .addr_q  (addr_q)
  );

  bdx_strobe_split split_i (
    .io_m  (io_m),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .stb   (stb),
    .clash (clash)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_region
    localparam logic [AW-1:0] BASE_G = REGION_BASE[g];
    bdx_region_decode #(.TAG_W(TAG_W), .TAG(BASE_G[AW-1:OFF_W])) dec_i (
      .tag_in (addr_nx[AW-1:OFF_W]),
      .hit    (hit[g])
    );
  end

  assign mem_cyc = stb.memr | stb.memw;

  always_ff @(posedge clk) begin
    if (rst) begin
      memr_n    <= 1'b1;
      memw_n    <= 1'b1;
      ior_n     <= 1'b1;
      iow_n     <= 1'b1;
      rom_cs_n  <= 1'b1;
      ram_cs_n  <= 1'b1;
      ram_we_n  <= 1'b1;
      data_oe_n <= 1'b1;
      data_dir  <= 1'b0;
      bus_err   <= 1'b0;
    end else begin
      memr_n    <= ~stb.memr;
      memw_n    <= ~stb.memw;
      ior_n     <= ~stb.ior;
      iow_n     <= ~stb.iow;
      rom_cs_n  <= ~(mem_cyc & hit[ROM_IDX]);
      ram_cs_n  <= ~(mem_cyc & hit[RAM_IDX]);
      ram_we_n  <= ~(stb.memw & hit[RAM_IDX]);
      data_oe_n <= ~any_strobe(stb);
      data_dir  <= is_read(stb);
      bus_err   <= clash;
    end
  end

  assign addr     = addr_q;
  assign chip_off = addr_q[OFF_W-1:0];

endmodule

// File: rtl/bdx_bus_glue_chk.sv
module bdx_bus_glue_chk #(
  parameter int LO_W = 8,
  parameter int HI_W = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ale,
  input logic [LO_W-1:0]      ad_in,
  input logic [HI_W-1:0]      a_hi,
  input logic                 io_m,
  input logic [LO_W+HI_W-1:0] addr,
  input logic                 memr_n,
  input logic                 memw_n,
  input logic                 ior_n,
  input logic                 iow_n,
  input logic                 rom_cs_n,
  input logic                 ram_cs_n,
  input logic                 ram_we_n,
  input logic                 bus_err
);

  localparam int AW = LO_W + HI_W;

  a_r1_follow: assert property (@(posedge clk) disable iff (rst)
    ale |=> (addr[LO_W-1:0] == $past(ad_in)));

  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    !ale |=> $stable(addr[LO_W-1:0]));

  a_r2_high_byte: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (addr[AW-1:LO_W] == $past(a_hi)));

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $countones({~memr_n, ~memw_n, ~ior_n, ~iow_n}) <= 1);

  a_r4_err_quiet: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (memr_n && memw_n && ior_n && iow_n));

  a_r6_no_cs_io: assert property (@(posedge clk) disable iff (rst)
    io_m |=> (rom_cs_n && ram_cs_n));

  a_r6_cs_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!rom_cs_n && !ram_cs_n));

  a_r7_no_rom_write: assert property (@(posedge clk) disable iff (rst)
    !rom_cs_n |-> ram_we_n);

endmodule

bind bdx_bus_glue bdx_bus_glue_chk #(.LO_W(LO_W), .HI_W(HI_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .ale      (ale),
  .ad_in    (ad_in),
  .a_hi     (a_hi),
  .io_m     (io_m),
  .addr     (addr),
  .memr_n   (memr_n),
  .memw_n   (memw_n),
  .ior_n    (ior_n),
  .iow_n    (iow_n),
  .rom_cs_n (rom_cs_n),
  .ram_cs_n (ram_cs_n),
  .ram_we_n (ram_we_n),
  .bus_err  (bus_err)
);

// File: tb/bdx_bus_glue_tb_top.sv
module bdx_bus_glue_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] addr;
    logic [12:0] off;
    logic        memr_n, memw_n, ior_n, iow_n;
    logic        rom_cs_n, ram_cs_n, ram_we_n;
    logic        oe_n, dir, err;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ale = 1'b0;
  logic [7:0]  ad_in = '0;
  logic [7:0]  a_hi = '0;
  logic        io_m = 1'b0;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;

  logic [15:0] addr;
  logic [12:0] chip_off;
  logic        memr_n, memw_n, ior_n, iow_n;
  logic        rom_cs_n, ram_cs_n, ram_we_n, data_oe_n, data_dir, bus_err;

  int   n_chk  = 0;
  int   n_fail = 0;
  exp_t q[$];
  logic [7:0] m_lo = '0;
  bit   done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bdx_bus_glue dut_i (
    .clk(clk), .rst(rst), .ale(ale), .ad_in(ad_in), .a_hi(a_hi),
    .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .chip_off(chip_off),
    .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n),
    .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n),
    .data_oe_n(data_oe_n), .data_dir(data_dir), .bus_err(bus_err)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: applies one cycle of inputs and pushes the predicted outputs.
  task automatic drive(input logic r, input logic a, input logic [7:0] ad,
                       input logic [7:0] hi, input logic io,
                       input logic rdn, input logic wrn);
    exp_t e;
    logic rd, wr, clash, mr, mw, ir, iw, mc, in_rom, in_ram;
    @(negedge clk);
    rst = r; ale = a; ad_in = ad; a_hi = hi; io_m = io; rd_n = rdn; wr_n = wrn;
    if (r) begin
      m_lo = '0;
      e = '{addr:16'h0, off:13'h0, memr_n:1, memw_n:1, ior_n:1, iow_n:1,
            rom_cs_n:1, ram_cs_n:1, ram_we_n:1, oe_n:1, dir:0, err:0};
    end else begin
      if (a) m_lo = ad;
      rd = ~rdn; wr = ~wrn; clash = rd & wr;
      mr = rd & ~wr & ~io; mw = wr & ~rd & ~io;
      ir = rd & ~wr & io;  iw = wr & ~rd & io;
      mc = mr | mw;
      e.addr = {hi, m_lo};
      e.off  = e.addr[12:0];
      in_rom = (e.addr < 16'h2000);
      in_ram = (e.addr >= 16'h2000) && (e.addr < 16'h4000);
      e.memr_n = ~mr; e.memw_n = ~mw; e.ior_n = ~ir; e.iow_n = ~iw;
      e.rom_cs_n = ~(mc & in_rom);
      e.ram_cs_n = ~(mc & in_ram);
      e.ram_we_n = ~(mw & in_ram);
      e.oe_n = ~(mr | mw | ir | iw);
      e.dir  = mr | ir;
      e.err  = clash;
    end
    q.push_back(e);
  endtask

  // Monitor: samples one time unit after each rising edge.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      if (e.addr == 16'h0 && e.memr_n && rst) chk("R10 reset addr", 32'(addr), 32'(e.addr));
      chk("R1 low address", 32'(addr[7:0]), 32'(e.addr[7:0]));
      chk("R2 high address", 32'(addr[15:8]), 32'(e.addr[15:8]));
      chk("R3 strobes", 32'({memr_n, memw_n, ior_n, iow_n}),
          32'({e.memr_n, e.memw_n, e.ior_n, e.iow_n}));
      chk("R4 error flag", 32'(bus_err), 32'(e.err));
      chk("R5 rom select", 32'(rom_cs_n), 32'(e.rom_cs_n));
      chk("R6 ram select", 32'(ram_cs_n), 32'(e.ram_cs_n));
      chk("R7 ram write", 32'(ram_we_n), 32'(e.ram_we_n));
      chk("R8 data path", 32'({data_oe_n, data_dir}), 32'({e.oe_n, e.dir}));
      chk("R9 chip offset", 32'(chip_off), 32'(e.off));
    end
  end

  // A read or write bus cycle: address phase, then junk on AD with strobe.
  task automatic bus_cycle(input logic [15:0] a, input logic io,
                           input logic rdn, input logic wrn);
    drive(0, 1, a[7:0], a[15:8], io, 1, 1);
    drive(0, 0, ~a[7:0], a[15:8], io, rdn, wrn);
    drive(0, 0, 8'h5A, a[15:8], io, rdn, wrn);
    drive(0, 0, 8'hC3, a[15:8], io, 1, 1);
  endtask

  initial begin
    // R10: reset state
    drive(1, 1, 8'hFF, 8'hFF, 0, 0, 1);
    drive(1, 0, 8'h00, 8'h00, 0, 1, 1);
    // R1: follow across two high cycles, then hold
    drive(0, 1, 8'h11, 8'h00, 0, 1, 1);
    drive(0, 1, 8'h22, 8'h00, 0, 1, 1);
    drive(0, 0, 8'h99, 8'h00, 0, 1, 1);
    // R3/R5: ROM reads at and near low edge
    bus_cycle(16'h0005, 0, 0, 1);
    bus_cycle(16'h1FFF, 0, 0, 1);
    // R6: RAM window edges
    bus_cycle(16'h2000, 0, 0, 1);
    bus_cycle(16'h3FFF, 0, 0, 1);
    bus_cycle(16'h2065, 0, 1, 0);
    bus_cycle(16'h3FFF, 0, 1, 0);
    // R7: write into ROM window gives no chip write
    bus_cycle(16'h1234, 0, 1, 0);
    // R6: outside both windows
    bus_cycle(16'h4000, 0, 0, 1);
    bus_cycle(16'h8000, 0, 1, 0);
    // R3/R6: I/O cycles at addresses that look like memory windows
    bus_cycle(16'h4040, 1, 0, 1);
    bus_cycle(16'h0000, 1, 1, 0);
    bus_cycle(16'h2121, 1, 0, 1);
    // R4: read and write together, memory and I/O
    bus_cycle(16'h0100, 0, 0, 0);
    bus_cycle(16'h2100, 1, 0, 0);
    // R10: reset mid-cycle
    drive(0, 1, 8'h77, 8'h30, 0, 1, 1);
    drive(1, 0, 8'h00, 8'h30, 0, 0, 1);
    drive(0, 0, 8'h00, 8'h30, 0, 0, 1);
    drive(0, 0, 8'h00, 8'h30, 0, 1, 1);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule